// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Aggregator

This block collects up to four 32-bit words of level-sensitive interrupt sources and drives several parent interrupt lines from them. Each word has a status register that samples the raw source levels once per clock, and an enable register in which a 1 lets the matching source through. The pending set of a word is its sampled status ANDed with its effective enable. Each parent line takes the OR of the pending bits picked out by a routing mask that is fixed at elaboration, one mask per pair of parent and word. When routing is switched off by parameter, every bit feeds every parent. Sources are level based, so nothing is acknowledged: a parent line drops as soon as the pending sources behind it go away.

At reset the enable registers take a forward-mask parameter, so the selected sources run from the first cycle and all others stay blocked until software enables them. A writable wake mask per word is merged into the enables while the suspend input is high, if wake support is built in. Writes to the enable register during suspend change the saved value, and the saved value is what remains when suspend drops.

Software reaches the registers through a plain strobe interface: one write strobe, and one read strobe whose data comes back with a valid flag one cycle later. No back-pressure applies; every strobe is served in the cycle it is given. Byte addresses are used and the two low address bits are ignored.

Top module: `l2_irq_router`

## Requirements
- R1: After reset each word's enable reads back the forward-mask parameter for that word, each wake mask reads 0, and every parent output is low.
- R2: Word w has its enable register at byte address 8*w and its status register at 8*w+4; its wake mask is at 0x20+4*w. A read strobe returns the addressed value on rdata_o with rd_valid_o high exactly one cycle later, and rd_valid_o is low in any cycle that follows a cycle without a read strobe.
- R3: The status register shows the source levels sampled at the previous clock edge and is read-only; a write to a status address changes nothing.
- R4: A 1 in an enable bit lets the matching source through and a 0 blocks it; a full-word write sets the enable register.
- R5: Parent p is high while any pending bit of word w selected by the routing mask of (p, w) is set, one cycle after the source rises.
- R6: A source bit that no parent's routing mask selects never drives any parent output, whatever its enable.
- R7: While suspend is high and wake support is built in, the effective enable of each word is its saved enable ORed with its wake mask, and reading the enable address returns that merged value.
- R8: A write to an enable register during suspend updates the saved value; when suspend drops, the saved value alone is the enable again.
- R9: No acknowledge exists: a parent output falls one cycle after all sources behind it fall.
- R10: With routing disabled by parameter, every bit of every word feeds every parent output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NWORDS*32 | Level-sensitive interrupt sources, word w in bits [32w+31:32w] |
| suspend_i | input | 1 | High during the low-power state; merges wake masks into enables |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | NPARENTS | Parent interrupt lines |

## Verification
Sources are raised in a forward-enabled bit, a blocked bit, bits routed to only one parent and bits routed to none, which separates a wrong enable polarity from a wrong routing mask and shows whether unrouted bits leak. Enable and wake patterns are then combined with suspend, so that a missing merge, a merge that overwrites the saved enable, or a restore that loses writes made during suspend each give a different parent value or read-back. A second instance with routing turned off receives the same word and shows that every bit reaches its only parent once it is enabled.

// File: rtl/l2_irq_pkg.sv
package l2_irq_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int MAX_WORDS = 4;
  // address bit that selects the wake-mask region
  localparam int WAKE_SEL_BIT = 5;
  // within the pair region: bit that picks status over enable
  localparam int STAT_SEL_BIT = 2;
endpackage

// File: rtl/l2_irq_word.sv
module l2_irq_word
  import l2_irq_pkg::*;
#(
  parameter logic [WORD_W-1:0] FWD          = '0,
  parameter bit                WAKE_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src_i,
  input  logic              suspend_i,
  input  logic              en_we_i,
  input  logic              wake_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] en_eff_o,
  output logic [WORD_W-1:0] wake_o,
  output logic [WORD_W-1:0] pend_o
);
  logic [WORD_W-1:0] stat_q, en_q, wake_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= FWD;
      wake_q <= '0;
    end else begin
      stat_q <= src_i;
      if (en_we_i)   en_q   <= wdata_i;
      if (wake_we_i) wake_q <= wdata_i;
    end
  end

  generate
    if (WAKE_SUPPORT) begin : g_wake
      assign en_eff_o = suspend_i ? (en_q | wake_q) : en_q;
    end else begin : g_nowake
      logic unused_susp;
      assign unused_susp = suspend_i;
      assign en_eff_o    = en_q;
    end
  endgenerate

  assign status_o = stat_q;
  assign wake_o   = wake_q;
  assign pend_o   = stat_q & en_eff_o;
endmodule

// File: rtl/l2_irq_route.sv
module l2_irq_route
  import l2_irq_pkg::*;
#(
  parameter int NWORDS    = 2,
  parameter int NPARENTS  = 2,
  parameter bit HAS_ROUTE = 1'b1,
  parameter logic [NPARENTS*NWORDS*WORD_W-1:0] ROUTE = '1
) (
  input  logic [NWORDS*WORD_W-1:0] pend_i,
  output logic [NPARENTS-1:0]      irq_o
);
  localparam int VEC_W = NWORDS * WORD_W;

  generate
    for (genvar p = 0; p < NPARENTS; p++) begin : g_parent
      localparam logic [VEC_W-1:0] SEL =
        HAS_ROUTE ? ROUTE[p*VEC_W +: VEC_W] : {VEC_W{1'b1}};
      assign irq_o[p] = |(pend_i & SEL);
    end
  endgenerate
endmodule

// File: rtl/l2_irq_regrd.sv
module l2_irq_regrd
  import l2_irq_pkg::*;
#(
  parameter int NWORDS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NWORDS*WORD_W-1:0] status_i,
  input  logic [NWORDS*WORD_W-1:0] en_i,
  input  logic [NWORDS*WORD_W-1:0] wake_i,
  output logic [WORD_W-1:0]        rdata_o,
  output logic                     rd_valid_o
);
  logic [WORD_W-1:0] sel;
  logic [1:0]        pair_idx, wake_idx;
  logic              unused_lsb;

  assign pair_idx   = addr_i[4:3];
  assign wake_idx   = addr_i[3:2];
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    sel = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (addr_i[WAKE_SEL_BIT]) begin
        if (!addr_i[4] && wake_idx == 2'(w)) sel = wake_i[w*WORD_W +: WORD_W];
      end else if (pair_idx == 2'(w)) begin
        sel = addr_i[STAT_SEL_BIT] ? status_i[w*WORD_W +: WORD_W]
                                   : en_i[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= sel;
    end
  end
endmodule

// File: rtl/l2_irq_router.sv
module l2_irq_router
  import l2_irq_pkg::*;
#(
  parameter int NWORDS       = 2,
  parameter int NPARENTS     = 2,
  parameter bit HAS_ROUTE    = 1'b1,
  parameter bit WAKE_SUPPORT = 1'b1,
  parameter logic [NPARENTS*NWORDS*WORD_W-1:0] ROUTE =
    {32'h0000_FF00, 32'hFFFF_0000, 32'h0000_00FF, 32'h0000_FFFF},
  parameter logic [NWORDS*WORD_W-1:0] FWD = {32'h0000_0000, 32'h0000_0003}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWORDS*WORD_W-1:0] src_i,
  input  logic                     suspend_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  output logic [WORD_W-1:0]        rdata_o,
  output logic                     rd_valid_o,
  output logic [NPARENTS-1:0]      irq_o
);
  localparam int VEC_W = NWORDS * WORD_W;

  logic [VEC_W-1:0] status_w, en_eff_w, wake_w, pend_w;

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic en_we, wake_we;
      assign en_we = wr_en_i && !addr_i[WAKE_SEL_BIT] && !addr_i[STAT_SEL_BIT]
                     && addr_i[4:3] == 2'(w);
      assign wake_we = wr_en_i && addr_i[WAKE_SEL_BIT] && !addr_i[4]
                       && addr_i[3:2] == 2'(w);

      l2_irq_word #(
        .FWD          (FWD[w*WORD_W +: WORD_W]),
        .WAKE_SUPPORT (WAKE_SUPPORT)
      ) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i[w*WORD_W +: WORD_W]),
        .suspend_i (suspend_i),
        .en_we_i   (en_we),
        .wake_we_i (wake_we),
        .wdata_i   (wdata_i),
        .status_o  (status_w[w*WORD_W +: WORD_W]),
        .en_eff_o  (en_eff_w[w*WORD_W +: WORD_W]),
        .wake_o    (wake_w[w*WORD_W +: WORD_W]),
        .pend_o    (pend_w[w*WORD_W +: WORD_W])
      );
    end
  endgenerate

  l2_irq_route #(
    .NWORDS    (NWORDS),
    .NPARENTS  (NPARENTS),
    .HAS_ROUTE (HAS_ROUTE),
    .ROUTE     (ROUTE)
  ) u_route (
    .pend_i (pend_w),
    .irq_o  (irq_o)
  );

  l2_irq_regrd #(
    .NWORDS (NWORDS)
  ) u_regrd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .status_i   (status_w),
    .en_i       (en_eff_w),
    .wake_i     (wake_w),
    .rdata_o    (rdata_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: rtl/l2_irq_router_chk.sv
module l2_irq_router_chk
  import l2_irq_pkg::*;
#(
  parameter int NWORDS       = 2,
  parameter int NPARENTS     = 2,
  parameter bit HAS_ROUTE    = 1'b1,
  parameter bit WAKE_SUPPORT = 1'b1,
  parameter logic [NPARENTS*NWORDS*WORD_W-1:0] ROUTE = '1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NWORDS*WORD_W-1:0] src_i,
  input logic                     suspend_i,
  input logic                     rd_en_i,
  input logic                     rd_valid_o,
  input logic [NPARENTS-1:0]      irq_o,
  input logic [NWORDS*WORD_W-1:0] en_eff,
  input logic [NWORDS*WORD_W-1:0] wake
);
  localparam int VEC_W = NWORDS * WORD_W;

  function automatic logic [VEC_W-1:0] any_route();
    logic [VEC_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < NPARENTS; p++) acc |= ROUTE[p*VEC_W +: VEC_W];
    return HAS_ROUTE ? acc : {VEC_W{1'b1}};
  endfunction

  localparam logic [VEC_W-1:0] ROUTED = any_route();

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_o == '0); // R1
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o); // R2
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o); // R2
  AST_UNROUTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i & ROUTED) == '0 |=> irq_o == '0); // R6
  AST_WAKE_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
    (WAKE_SUPPORT && suspend_i) |-> (en_eff & wake) == wake); // R7
  AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    src_i == '0 |=> irq_o == '0); // R9
endmodule

bind l2_irq_router l2_irq_router_chk #(
  .NWORDS       (NWORDS),
  .NPARENTS     (NPARENTS),
  .HAS_ROUTE    (HAS_ROUTE),
  .WAKE_SUPPORT (WAKE_SUPPORT),
  .ROUTE        (ROUTE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_i      (src_i),
  .suspend_i  (suspend_i),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .irq_o      (irq_o),
  .en_eff     (en_eff_w),
  .wake       (wake_w)
);

// File: tb/test_l2_irq_router.sv
module test_l2_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        suspend = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [1:0]  irq;
  logic [31:0] o_rdata;
  logic        o_rd_valid;
  logic [0:0]  o_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  l2_irq_router i_l2_irq_router (
    .clk(clk), .rst_n(rst_n), .src_i(src), .suspend_i(suspend),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rd_valid_o(rd_valid), .irq_o(irq)
  );

  // routing disabled, one word, one parent, bit 4 forwarded
  l2_irq_router #(
    .NWORDS(1), .NPARENTS(1), .HAS_ROUTE(1'b0), .WAKE_SUPPORT(1'b0),
    .ROUTE(32'hFFFF_FFFF), .FWD(32'h0000_0010)
  ) i_l2_irq_router_open (
    .clk(clk), .rst_n(rst_n), .src_i(src[31:0]), .suspend_i(1'b0),
    .wr_en_i(1'b0), .rd_en_i(1'b0), .addr_i(6'd0), .wdata_i(32'd0),
    .rdata_o(o_rdata), .rd_valid_o(o_rd_valid), .irq_o(o_irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // read monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(rdata, 32'hDEAD_BEEF, "R2 unexpected read data");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      if (exp_q.size() != 0) check(32'(exp_q.size()), 32'd0, "R2 reads left unanswered");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(32'(irq), 32'd0, "R1 irq after reset");
    rd(6'h00, 32'h0000_0003, "R1 enable word0 = forward mask");
    rd(6'h08, 32'h0000_0000, "R1 enable word1 = forward mask");
    rd(6'h20, 32'h0000_0000, "R1 wake word0");
    // R4 forwarded bit passes, blocked bit does not
    set_src(64'h0000_0000_0002_0001);
    check(32'(irq), 32'h1, "R4 forwarded bit0 to parent0, bit17 blocked");
    wr(6'h00, 32'h0003_0003);
    check(32'(irq), 32'h3, "R5 bit17 enabled reaches parent1");
    // R3 status read and write ignored
    rd(6'h04, 32'h0002_0001, "R3 status word0");
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, 32'h0002_0001, "R3 status write ignored");
    rd(6'h00, 32'h0003_0003, "R3 enable untouched by status write");
    // R6 unrouted bits of word1
    wr(6'h08, 32'hFFFF_FFFF);
    set_src(64'hFFFF_0000_0000_0000);
    check(32'(irq), 32'h0, "R6 unrouted word1 bits");
    set_src(64'h0000_0100_0000_0000);
    check(32'(irq), 32'h2, "R5 word1 bit8 to parent1");
    set_src(64'h0000_0001_0000_0000);
    check(32'(irq), 32'h1, "R5 word1 bit0 to parent0");
    rd(6'h0C, 32'h0000_0001, "R2 status word1 address");
    // R9 level drop
    set_src(64'h0);
    check(32'(irq), 32'h0, "R9 output falls with source");
    // R7 suspend wake merge
    wr(6'h00, 32'h0000_0000);
    wr(6'h20, 32'h0000_0001);
    rd(6'h20, 32'h0000_0001, "R2 wake word0 address");
    set_src(64'h0000_0000_0000_0001);
    check(32'(irq), 32'h0, "R4 disabled source blocked");
    @(negedge clk); suspend = 1'b1;
    @(negedge clk);
    check(32'(irq), 32'h1, "R7 wake bit enabled in suspend");
    rd(6'h00, 32'h0000_0001, "R7 merged enable read");
    // R8 write during suspend, then resume
    wr(6'h00, 32'h0001_0000);
    rd(6'h00, 32'h0001_0001, "R8 merged after suspend write");
    @(negedge clk); suspend = 1'b0;
    @(negedge clk);
    check(32'(irq), 32'h0, "R8 wake bit gone after resume");
    rd(6'h00, 32'h0001_0000, "R8 saved enable restored");
    set_src(64'h0000_0000_0001_0000);
    check(32'(irq), 32'h2, "R8 suspend write kept after resume");
    // R10 routing disabled
    set_src(64'h0000_0000_0000_0010);
    check(32'(o_irq), 32'h1, "R10 bit4 reaches only parent");
    set_src(64'h0000_0000_0000_0001);
    check(32'(o_irq), 32'h0, "R10 non-forwarded bit blocked");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule